// File: doc/BRIEF.md
# Multi-cycle 16-bit controller/datapath processor

The block is a small 16-bit processor split into a finite-state controller and a datapath. The controller walks each instruction through fetch, a wait for memory data, decode and a single execute state; loads take one extra state while memory answers. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers with two read ports and one write port, an adder/subtractor with a zero output, a mux choosing what is written back to the registers, and a mux choosing the memory address.

Instructions and data share one word-addressed memory port outside the block. Read data must arrive on the cycle after a read request. Each instruction word is laid out as opcode in bits 15:12, first register (A) in bits 11:8 and second register (B) in bits 7:4. An 8-bit field in bits 7:0 serves as direct address, immediate or branch offset. Any opcode outside the seven defined ones stops the processor and raises a halt flag.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high, `mem_rd`, `mem_wr` and `halted` are low. After reset is released, the first memory request is a read of address 0.
- R2: Each instruction is fetched by a read at the program counter, with data taken on the next cycle. The program counter then advances by one, so instructions run in address order unless a jump is taken.
- R3: Opcode 0000 loads register A from memory at the zero-extended address in bits 7:0. Opcode 0001 writes register A to memory at that address.
- R4: Opcode 0010 writes register B to memory at the address held in register A.
- R5: Opcode 0011 loads register A with bits 7:0 zero-extended to 16 bits.
- R6: Opcode 0100 sets A = A + B and opcode 0101 sets A = A - B, both modulo 2^16.
- R7: Opcode 0110 adds the sign-extended bits 7:0 to the already-incremented program counter when register A is zero. Otherwise execution falls through to the next word.
- R8: Opcodes 0111 through 1111 make `halted` go high and stay high. From then on there are no further memory reads or writes until reset.
- R9: In no cycle are `mem_rd` and `mem_wr` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address for the memory request |
| mem_rd | output | 1 | Read request; data expected next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Data for a write |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
A counting loop that sums ten down to one runs the jump both ways, including a backward jump with a negative offset. A design that sign-extends wrongly, or that adds the offset to the un-incremented counter, ends with the wrong total or never halts. A sweep of add, subtract and jump-if-zero over operand pairs at 0, 1, 127, 128 and 255 reaches the wrap to 0xFFFF and the equal-operand case, which is where a design that took the branch decision from the wrong register would skip or perform a store wrongly. Every undefined opcode is tried, followed by a store that must never happen. An immediate of 0xFF must read back as 0x00FF, which catches a design that sign-extends it.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
    localparam int XLEN   = 16;
    localparam int NREGS  = 16;
    localparam int RIDX   = $clog2(NREGS);
    localparam int OPW    = 4;
    localparam int FLDW   = 8;

    typedef enum logic [OPW-1:0] {
        OP_LD  = 4'h0,
        OP_ST  = 4'h1,
        OP_STI = 4'h2,
        OP_LDI = 4'h3,
        OP_ADD = 4'h4,
        OP_SUB = 4'h5,
        OP_JZ  = 4'h6
    } opcode_e;

    typedef enum logic [3:0] {
        ST_RESET, ST_FETCH, ST_FWAIT, ST_DECODE,
        ST_LDREQ, ST_LDWB, ST_ST, ST_STI, ST_LDI,
        ST_ADD, ST_SUB, ST_JZ, ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'b00,
        WB_MEM = 2'b01,
        WB_IMM = 2'b10
    } wb_sel_e;

    typedef enum logic [1:0] {
        ADDR_PC  = 2'b00,
        ADDR_DIR = 2'b01,
        ADDR_REG = 2'b10
    } addr_sel_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01
    } alu_op_e;

    typedef struct packed {
        logic      pc_clear;
        logic      pc_inc;
        logic      pc_jump;
        logic      ir_load;
        logic      rf_we;
        wb_sel_e   wb_sel;
        alu_op_e   alu_op;
        logic      b_zero;
        addr_sel_e addr_sel;
        logic      wdata_b;
        logic      mem_rd;
        logic      mem_wr;
    } ctrl_t;

    function automatic logic [XLEN-1:0] zext_fld(input logic [FLDW-1:0] f);
        return {{(XLEN-FLDW){1'b0}}, f};
    endfunction

    function automatic logic [XLEN-1:0] sext_fld(input logic [FLDW-1:0] f);
        return {{(XLEN-FLDW){f[FLDW-1]}}, f};
    endfunction
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RIDX-1:0] ra_a,
    input  logic [RIDX-1:0] ra_b,
    input  logic            we,
    input  logic [RIDX-1:0] wa,
    input  logic [XLEN-1:0] wd,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output ctrl_t          ctl,
    output state_e         state_o,
    output logic           halted
);
    state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= nxt;
    end

    always_comb begin
        ctl = '0;
        nxt = state;
        case (state)
            ST_RESET:  begin ctl.pc_clear = 1'b1; nxt = ST_FETCH; end
            ST_FETCH:  begin ctl.addr_sel = ADDR_PC; ctl.mem_rd = 1'b1; nxt = ST_FWAIT; end
            ST_FWAIT:  begin ctl.ir_load = 1'b1; ctl.pc_inc = 1'b1; nxt = ST_DECODE; end
            ST_DECODE: begin
                case (opcode)
                    OP_LD:   nxt = ST_LDREQ;
                    OP_ST:   nxt = ST_ST;
                    OP_STI:  nxt = ST_STI;
                    OP_LDI:  nxt = ST_LDI;
                    OP_ADD:  nxt = ST_ADD;
                    OP_SUB:  nxt = ST_SUB;
                    OP_JZ:   nxt = ST_JZ;
                    default: nxt = ST_HALT;
                endcase
            end
            ST_LDREQ:  begin ctl.addr_sel = ADDR_DIR; ctl.mem_rd = 1'b1; nxt = ST_LDWB; end
            ST_LDWB:   begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_MEM; nxt = ST_FETCH; end
            ST_ST:     begin ctl.addr_sel = ADDR_DIR; ctl.mem_wr = 1'b1; nxt = ST_FETCH; end
            ST_STI:    begin
                ctl.addr_sel = ADDR_REG; ctl.mem_wr = 1'b1; ctl.wdata_b = 1'b1;
                nxt = ST_FETCH;
            end
            ST_LDI:    begin ctl.rf_we = 1'b1; ctl.wb_sel = WB_IMM; nxt = ST_FETCH; end
            ST_ADD:    begin
                ctl.rf_we = 1'b1; ctl.wb_sel = WB_ALU; ctl.alu_op = ALU_ADD;
                nxt = ST_FETCH;
            end
            ST_SUB:    begin
                ctl.rf_we = 1'b1; ctl.wb_sel = WB_ALU; ctl.alu_op = ALU_SUB;
                nxt = ST_FETCH;
            end
            ST_JZ:     begin
                ctl.alu_op = ALU_ADD; ctl.b_zero = 1'b1; ctl.pc_jump = 1'b1;
                nxt = ST_FETCH;
            end
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_HALT;
        endcase
    end

    assign state_o = state;
    assign halted  = (state == ST_HALT);

    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET) |=> (ctl.mem_rd && ctl.addr_sel == ADDR_PC));

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!ctl.mem_rd && !ctl.mem_wr));

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.mem_rd, ctl.mem_wr}));
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            halted
);
    ctrl_t           ctl;
    state_e          state;
    logic [XLEN-1:0] pc, ir;
    logic [XLEN-1:0] rd_a, rd_b, alu_b, alu_y, wb_data;
    logic            alu_zero;
    logic [RIDX-1:0] fld_a, fld_b;
    logic [FLDW-1:0] fld_k;

    assign fld_a = ir[XLEN-OPW-1 -: RIDX];
    assign fld_b = ir[FLDW-1 -: RIDX];
    assign fld_k = ir[FLDW-1:0];

    cpu16_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .opcode  (ir[XLEN-1 -: OPW]),
        .ctl     (ctl),
        .state_o (state),
        .halted  (halted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            ir <= '0;
        end else begin
            if (ctl.pc_clear)                pc <= '0;
            else if (ctl.pc_inc)             pc <= pc + 16'd1;
            else if (ctl.pc_jump && alu_zero) pc <= pc + sext_fld(fld_k);
            if (ctl.ir_load) ir <= mem_rdata;
        end
    end

    always_comb begin
        case (ctl.wb_sel)
            WB_MEM:  wb_data = mem_rdata;
            WB_IMM:  wb_data = zext_fld(fld_k);
            default: wb_data = alu_y;
        endcase
    end

    cpu16_regfile u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (fld_a),
        .ra_b (fld_b),
        .we   (ctl.rf_we),
        .wa   (fld_a),
        .wd   (wb_data),
        .rd_a (rd_a),
        .rd_b (rd_b)
    );

    assign alu_b = ctl.b_zero ? '0 : rd_b;

    cpu16_alu u_alu (
        .op   (ctl.alu_op),
        .a    (rd_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        case (ctl.addr_sel)
            ADDR_DIR: mem_addr = zext_fld(fld_k);
            ADDR_REG: mem_addr = rd_a;
            default:  mem_addr = pc;
        endcase
    end

    assign mem_wdata = ctl.wdata_b ? rd_b : rd_a;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;

    // R2
    fetch_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FWAIT) |=> (pc == $past(pc) + 16'd1));

    // R7
    jz_fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && rd_a != '0) |=> (pc == $past(pc)));

    // R7
    jz_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_JZ && rd_a == '0) |=> (pc == $past(pc) + sext_fld($past(fld_k))));
endmodule

// File: tb/cpu16_core_bench.sv
module cpu16_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, halted;

    logic [15:0] mem  [256];
    logic [15:0] prog [32];
    int          n_chk = 0;
    int          n_fail = 0;
    int          post_wr = 0;

    always #2 clk = ~clk;

    cpu16_core u_cpu16_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            if (halted) post_wr <= post_wr + 1;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    end

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [3:0] a,
                                       input logic [7:0] k);
        return {op, a, k};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic run_prog(input int len, input int limit);
        int waited;
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
        for (int i = 0; i < len; i++) mem[i] = prog[i];
        post_wr = 0;
        repeat (2) @(negedge clk);
        chk("R1 reset quiet", {13'd0, mem_rd, mem_wr, halted}, 16'd0);
        rst = 1'b0;
        waited = 0;
        while (!mem_rd && waited < 8) begin @(negedge clk); waited++; end
        chk("R1 first read address", mem_addr, 16'h0000);
        waited = 0;
        while (!halted && waited < limit) begin @(negedge clk); waited++; end
        if (!halted) begin
            n_chk++; n_fail++;
            $display("FAIL R8 run watchdog: actual halted=0 expected halted=1");
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] vals [5];
        vals = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd255};

        // Summation loop plus direct, indirect and immediate accesses
        prog[0]  = mk(4'h3, 4'd0, 8'd0);
        prog[1]  = mk(4'h3, 4'd1, 8'd10);
        prog[2]  = mk(4'h3, 4'd2, 8'd1);
        prog[3]  = mk(4'h3, 4'd3, 8'd0);
        prog[4]  = mk(4'h6, 4'd1, 8'd3);
        prog[5]  = mk(4'h4, 4'd0, 8'h10);
        prog[6]  = mk(4'h5, 4'd1, 8'h20);
        prog[7]  = mk(4'h6, 4'd3, 8'hFC);
        prog[8]  = mk(4'h1, 4'd0, 8'h80);
        prog[9]  = mk(4'h0, 4'd5, 8'h80);
        prog[10] = mk(4'h3, 4'd6, 8'h90);
        prog[11] = mk(4'h2, 4'd6, 8'h50);
        prog[12] = mk(4'h3, 4'd7, 8'hFF);
        prog[13] = mk(4'h1, 4'd7, 8'h81);
        prog[14] = mk(4'h5, 4'd3, 8'h20);
        prog[15] = mk(4'h1, 4'd3, 8'h82);
        prog[16] = 16'h7000;
        run_prog(17, 2000);
        chk("R7 R6 R3 loop sum stored direct", mem[8'h80], 16'd55);
        chk("R4 R3 indirect store of loaded value", mem[8'h90], 16'd55);
        chk("R5 immediate zero-extended", mem[8'h81], 16'h00FF);
        chk("R6 subtract wraps", mem[8'h82], 16'hFFFF);
        chk("R8 halted held", {15'd0, halted}, 16'd1);
        chk("R8 no write after halt", post_wr[15:0], 16'd0);
        chk("R2 memory past program untouched", mem[8'h11], 16'hDEAD);

        // Add / subtract / jump sweep
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                logic [15:0] a, b;
                a = {8'd0, vals[i]};
                b = {8'd0, vals[j]};
                prog[0] = mk(4'h3, 4'd1, vals[i]);
                prog[1] = mk(4'h3, 4'd2, vals[j]);
                prog[2] = mk(4'h4, 4'd1, 8'h20);
                prog[3] = mk(4'h1, 4'd1, 8'hA0);
                prog[4] = mk(4'h3, 4'd3, vals[i]);
                prog[5] = mk(4'h5, 4'd3, 8'h20);
                prog[6] = mk(4'h1, 4'd3, 8'hA1);
                prog[7] = mk(4'h6, 4'd3, 8'h01);
                prog[8] = mk(4'h1, 4'd2, 8'hA2);
                prog[9] = 16'hF000;
                run_prog(10, 500);
                chk("R6 add", mem[8'hA0], a + b);
                chk("R6 sub", mem[8'hA1], a - b);
                chk("R7 jump-if-zero skip", mem[8'hA2], (a == b) ? 16'hDEAD : b);
            end
        end

        // Every undefined opcode halts before the following store
        for (int op = 7; op < 16; op++) begin
            prog[0] = mk(4'h3, 4'd1, 8'd1);
            prog[1] = {op[3:0], 12'h000};
            prog[2] = mk(4'h1, 4'd1, 8'hA3);
            prog[3] = 16'hF000;
            run_prog(4, 200);
            chk("R8 undefined opcode halts", {15'd0, halted}, 16'd1);
            chk("R8 store after halt suppressed", mem[8'hA3], 16'hDEAD);
            chk("R9 R8 no write while halted", post_wr[15:0], 16'd0);
        end

        finish_run();
    end
endmodule